// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block steps a single scalar operation across a run of vector elements. A caller hands it base register numbers for one destination and two sources, a flag per operand saying whether that operand walks through consecutive registers or stays fixed, an element count and a predicate mask word. The sequencer then issues one element per cycle over a valid/ready handshake. Each issue carries three register numbers, a write enable and the element number.

For each operand, the register number is the operand's base plus an offset. A vectorised operand's offset follows the element number. A scalar operand's offset is held at zero. The write enable for an element is the matching predicate bit. Masked-off elements are still issued, with the enable low, so the downstream order stays dense.

An optional remap hook exposes each operand's raw offset on output ports and takes a replacement offset back on input ports. The hook is selected when a sequence starts, which lets an external schedule (a transposition or a bit reversal, for example) reorder register accesses without any change to the sequencer.

Top module: `vec_elem_seq`

## Requirements
- R1: A `start` seen while idle launches a sequence. From the next cycle `iss_valid` is high, and `iss_idx` runs from 0 up to the effective length minus one, advancing by one per accepted issue (`iss_valid` and `iss_ready` both high).
- R2: `iss_we` equals bit `iss_idx` of the predicate mask captured at start, and is low whenever `iss_valid` is low. Changes to `pmask` after start have no effect.
- R3: A vectorised operand (flag bit 0 = destination, bit 1 = source A, bit 2 = source B) has raw offset equal to `iss_idx`. Its register number is base plus offset modulo 2^REG_W, wrapping past the top register.
- R4: A non-vectorised operand has raw offset 0. Its register number stays at its base for the whole sequence.
- R5: When `remap_en` is high at start, each register number is base plus the matching `map_*` input instead of the raw offset. The raw offsets are always driven on `ofs_*`.
- R6: While `iss_valid` is high and `iss_ready` is low, the issue outputs hold and no element is lost.
- R7: `done` pulses for one cycle in the cycle after the final accepted issue, with `iss_valid` low in that cycle. The block is then idle.
- R8: A start with `vl` = 0 produces no issue, and `done` pulses in the next cycle.
- R9: A `vl` above MAXVL is treated as MAXVL.
- R10: `start` and all configuration inputs are ignored while a sequence is running.
- R11: After reset, `iss_valid`, `iss_we` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, taken only when idle |
| vl | input | VL_W | Element count |
| pmask | input | MAXVL | Predicate mask, bit i enables element i |
| base_dst | input | REG_W | Destination base register |
| base_srca | input | REG_W | Source A base register |
| base_srcb | input | REG_W | Source B base register |
| vec_flags | input | 3 | Vectorised flags: bit0 dst, bit1 srcA, bit2 srcB |
| remap_en | input | 1 | Use the remap hook for this sequence |
| ofs_dst | output | IDX_W | Raw destination offset to the remap stage |
| ofs_srca | output | IDX_W | Raw source A offset to the remap stage |
| ofs_srcb | output | IDX_W | Raw source B offset to the remap stage |
| map_dst | input | IDX_W | Remapped destination offset |
| map_srca | input | IDX_W | Remapped source A offset |
| map_srcb | input | IDX_W | Remapped source B offset |
| iss_valid | output | 1 | Element issue valid |
| iss_ready | input | 1 | Downstream accepts the issue |
| iss_idx | output | IDX_W | Element number |
| iss_dst | output | REG_W | Destination register number |
| iss_srca | output | REG_W | Source A register number |
| iss_srcb | output | REG_W | Source B register number |
| iss_we | output | 1 | Write enable from the predicate |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions check these properties:
- a stalled issue holds;
- the element number starts at zero, advances by one per handshake and stays below the length;
- a write enable implies a valid issue;
- scalar operands keep their register, and vectorised operands step by one without remap;
- `done` never coincides with an issue;
- a zero length finishes at once.

Some properties can only be shown by the bench's scenarios, which compare against a behavioural model on every clock:
- the exact predicate pattern, including a mask change after start;
- register wrap at the top of the file;
- length clamping;
- the remap hook through a bit-reversing external stage;
- a start ignored while busy.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    localparam int NUM_OPS = 3;
    localparam int OP_DST  = 0;
    localparam int OP_SRCA = 1;
    localparam int OP_SRCB = 2;

    // bits needed to number n elements (at least one)
    function automatic int idx_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // bits needed to hold a count from 0 to n
    function automatic int cnt_bits(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
    import vseq_pkg::*;
#(
    parameter int MAXVL = 64,
    parameter int VL_W  = 7,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VL_W-1:0]  vl_in,
    input  logic [MAXVL-1:0] mask_in,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [IDX_W-1:0] idx,
    output logic             we,
    output logic             accept,
    output logic             done
);

    localparam logic [VL_W-1:0] LEN_CAP = VL_W'(MAXVL);

    seq_state_e       state;
    logic [VL_W-1:0]  len_q;
    logic [MAXVL-1:0] mask_q;
    logic [VL_W-1:0]  eff_len;
    logic             last;

    assign eff_len   = (vl_in > LEN_CAP) ? LEN_CAP : vl_in;
    assign accept    = start && (state == ST_IDLE);
    assign out_valid = (state == ST_RUN);
    assign last      = ((VL_W'(idx) + VL_W'(1)) == len_q);
    assign we        = out_valid && mask_q[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            len_q  <= '0;
            mask_q <= '0;
            idx    <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        mask_q <= mask_in;
                        len_q  <= eff_len;
                        idx    <= '0;
                        if (eff_len == '0) done  <= 1'b1;
                        else               state <= ST_RUN;
                    end
                end
                default: begin
                    if (out_ready) begin
                        if (last) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(idx) && $stable(we)));

    p_first_zero_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (idx == '0));

    p_advance_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !last) |=> (out_valid && idx == $past(idx) + IDX_W'(1)));

    p_idx_range_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (VL_W'(idx) < len_q));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid);

    p_empty_done_r8: assert property (@(posedge clk) disable iff (rst)
        (accept && vl_in == '0) |=> (done && !out_valid));

endmodule

// File: rtl/vseq_opgen.sv
module vseq_opgen #(
    parameter int REG_W = 7,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [REG_W-1:0] base_in,
    input  logic             vec_in,
    input  logic             remap_q,
    input  logic             step_valid,
    input  logic             step_fire,
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] map_ofs,
    output logic [IDX_W-1:0] raw_ofs,
    output logic [REG_W-1:0] reg_num
);

    logic [REG_W-1:0] base_q;
    logic             vec_q;
    logic [IDX_W-1:0] use_ofs;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            vec_q  <= 1'b0;
        end else if (load) begin
            base_q <= base_in;
            vec_q  <= vec_in;
        end
    end

    assign raw_ofs = vec_q ? idx : '0;
    assign use_ofs = remap_q ? map_ofs : raw_ofs;
    assign reg_num = base_q + REG_W'(use_ofs);

    p_scalar_fixed_r4: assert property (@(posedge clk) disable iff (rst)
        (step_valid && !vec_q && !remap_q) |=> (!step_valid || $stable(reg_num)));

    p_vec_step_r3: assert property (@(posedge clk) disable iff (rst)
        (step_fire && vec_q && !remap_q) |=>
        (!step_valid || reg_num == $past(reg_num) + REG_W'(1)));

endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
    import vseq_pkg::*;
#(
    parameter int MAXVL = 64,
    parameter int REG_W = 7,
    parameter int VL_W  = cnt_bits(MAXVL),
    parameter int IDX_W = idx_bits(MAXVL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VL_W-1:0]  vl,
    input  logic [MAXVL-1:0] pmask,
    input  logic [REG_W-1:0] base_dst,
    input  logic [REG_W-1:0] base_srca,
    input  logic [REG_W-1:0] base_srcb,
    input  logic [2:0]       vec_flags,
    input  logic             remap_en,
    output logic [IDX_W-1:0] ofs_dst,
    output logic [IDX_W-1:0] ofs_srca,
    output logic [IDX_W-1:0] ofs_srcb,
    input  logic [IDX_W-1:0] map_dst,
    input  logic [IDX_W-1:0] map_srca,
    input  logic [IDX_W-1:0] map_srcb,
    output logic             iss_valid,
    input  logic             iss_ready,
    output logic [IDX_W-1:0] iss_idx,
    output logic [REG_W-1:0] iss_dst,
    output logic [REG_W-1:0] iss_srca,
    output logic [REG_W-1:0] iss_srcb,
    output logic             iss_we,
    output logic             done
);

    logic accept;
    logic remap_q;

    logic [REG_W-1:0] base_arr [NUM_OPS];
    logic [IDX_W-1:0] map_arr  [NUM_OPS];
    logic [IDX_W-1:0] raw_arr  [NUM_OPS];
    logic [REG_W-1:0] reg_arr  [NUM_OPS];

    vseq_ctrl #(
        .MAXVL (MAXVL),
        .VL_W  (VL_W),
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .vl_in     (vl),
        .mask_in   (pmask),
        .out_ready (iss_ready),
        .out_valid (iss_valid),
        .idx       (iss_idx),
        .we        (iss_we),
        .accept    (accept),
        .done      (done)
    );

    always_ff @(posedge clk) begin
        if (rst)         remap_q <= 1'b0;
        else if (accept) remap_q <= remap_en;
    end

    assign base_arr[OP_DST]  = base_dst;
    assign base_arr[OP_SRCA] = base_srca;
    assign base_arr[OP_SRCB] = base_srcb;
    assign map_arr[OP_DST]   = map_dst;
    assign map_arr[OP_SRCA]  = map_srca;
    assign map_arr[OP_SRCB]  = map_srcb;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        vseq_opgen #(
            .REG_W (REG_W),
            .IDX_W (IDX_W)
        ) u_opgen (
            .clk        (clk),
            .rst        (rst),
            .load       (accept),
            .base_in    (base_arr[g]),
            .vec_in     (vec_flags[g]),
            .remap_q    (remap_q),
            .step_valid (iss_valid),
            .step_fire  (iss_valid && iss_ready),
            .idx        (iss_idx),
            .map_ofs    (map_arr[g]),
            .raw_ofs    (raw_arr[g]),
            .reg_num    (reg_arr[g])
        );
    end

    assign ofs_dst  = raw_arr[OP_DST];
    assign ofs_srca = raw_arr[OP_SRCA];
    assign ofs_srcb = raw_arr[OP_SRCB];
    assign iss_dst  = reg_arr[OP_DST];
    assign iss_srca = reg_arr[OP_SRCA];
    assign iss_srcb = reg_arr[OP_SRCB];

    p_we_valid_r2: assert property (@(posedge clk) disable iff (rst)
        iss_we |-> iss_valid);

    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && start) |=> $stable(remap_q));

endmodule

// File: tb/vec_elem_seq_test.sv
module vec_elem_seq_test;

    localparam int MAXVL = 64;
    localparam int REG_W = 7;
    localparam int VL_W  = 7;
    localparam int IDX_W = 6;
    localparam int WD_LIMIT = 20000;

    logic clk = 1'b0;
    logic rst;
    logic start;
    logic [VL_W-1:0] vl;
    logic [MAXVL-1:0] pmask;
    logic [REG_W-1:0] base_dst, base_srca, base_srcb;
    logic [2:0] vec_flags;
    logic remap_en;
    logic [IDX_W-1:0] ofs_dst, ofs_srca, ofs_srcb;
    logic [IDX_W-1:0] map_dst, map_srca, map_srcb;
    logic iss_valid, iss_ready, iss_we, done;
    logic [IDX_W-1:0] iss_idx;
    logic [REG_W-1:0] iss_dst, iss_srca, iss_srcb;

    always #4 clk = ~clk;

    function automatic logic [IDX_W-1:0] rev(input logic [IDX_W-1:0] v);
        logic [IDX_W-1:0] r;
        for (int b = 0; b < IDX_W; b++) r[b] = v[IDX_W-1-b];
        return r;
    endfunction

    // external remap stage: bit reversal of the raw offset
    assign map_dst  = rev(ofs_dst);
    assign map_srca = rev(ofs_srca);
    assign map_srcb = rev(ofs_srcb);

    vec_elem_seq #(.MAXVL(MAXVL), .REG_W(REG_W)) uut (
        .clk(clk), .rst(rst), .start(start), .vl(vl), .pmask(pmask),
        .base_dst(base_dst), .base_srca(base_srca), .base_srcb(base_srcb),
        .vec_flags(vec_flags), .remap_en(remap_en),
        .ofs_dst(ofs_dst), .ofs_srca(ofs_srca), .ofs_srcb(ofs_srcb),
        .map_dst(map_dst), .map_srca(map_srca), .map_srcb(map_srcb),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_idx(iss_idx),
        .iss_dst(iss_dst), .iss_srca(iss_srca), .iss_srcb(iss_srcb),
        .iss_we(iss_we), .done(done)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit wd = 0;
    string ctx = "";
    logic [15:0] lfsr = 16'hACE1;

    // behavioural model state
    bit m_busy, m_done, m_rmap, m_stalled;
    int m_idx, m_len;
    logic [MAXVL-1:0] m_mask;
    int m_base [3];
    bit m_vec [3];

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, ctx, act, exp, cyc);
        end
    endtask

    function automatic int exp_reg(input int op);
        int raw, off;
        raw = m_vec[op] ? m_idx : 0;
        off = m_rmap ? int'(rev(IDX_W'(raw))) : raw;
        return (m_base[op] + off) % (1 << REG_W);
    endfunction

    function automatic int exp_raw(input int op);
        return m_vec[op] ? m_idx : 0;
    endfunction

    task automatic model_step();
        bit nd;
        m_stalled = 0;
        if (rst) begin
            m_busy = 0; m_done = 0; m_idx = 0;
        end else begin
            nd = 0;
            if (!m_busy) begin
                if (start) begin
                    m_len = (int'(vl) > MAXVL) ? MAXVL : int'(vl);
                    m_mask = pmask;
                    m_base[0] = base_dst; m_base[1] = base_srca; m_base[2] = base_srcb;
                    for (int k = 0; k < 3; k++) m_vec[k] = vec_flags[k];
                    m_rmap = remap_en;
                    m_idx = 0;
                    if (m_len == 0) nd = 1;
                    else m_busy = 1;
                end
            end else if (iss_ready) begin
                if (m_idx == m_len - 1) begin
                    m_busy = 0; nd = 1;
                end else m_idx++;
            end else begin
                m_stalled = 1;
            end
            m_done = nd;
        end
    endtask

    task automatic compare();
        string rq;
        check(iss_valid == m_busy, m_len == 0 ? "R8" : "R1", iss_valid, m_busy);
        check(done == m_done, "R7", done, m_done);
        if (!m_busy) check(iss_we == 1'b0, "R2", iss_we, 0);
        if (m_busy) begin
            check(iss_idx == m_idx, m_stalled ? "R6" : "R1", iss_idx, m_idx);
            check(iss_we == m_mask[m_idx], "R2", iss_we, m_mask[m_idx]);
            rq = m_rmap ? "R5" : (m_vec[0] ? "R3" : "R4");
            check(iss_dst == exp_reg(0), rq, iss_dst, exp_reg(0));
            rq = m_rmap ? "R5" : (m_vec[1] ? "R3" : "R4");
            check(iss_srca == exp_reg(1), rq, iss_srca, exp_reg(1));
            rq = m_rmap ? "R5" : (m_vec[2] ? "R3" : "R4");
            check(iss_srcb == exp_reg(2), rq, iss_srcb, exp_reg(2));
            check(ofs_dst == exp_raw(0), "R5", ofs_dst, exp_raw(0));
            check(ofs_srca == exp_raw(1), "R5", ofs_srca, exp_raw(1));
            check(ofs_srcb == exp_raw(2), "R5", ofs_srcb, exp_raw(2));
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cyc++;
        if (cyc > WD_LIMIT && !wd) begin
            wd = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WD_LIMIT);
        end
    endtask

    task automatic run_seq(input string tag, input int vl_v, input logic [MAXVL-1:0] mk,
                           input int bd, input int ba, input int bb, input logic [2:0] fl,
                           input bit rm, input bit stall, input bit midstart);
        int n;
        ctx = tag;
        vl = VL_W'(vl_v); pmask = mk;
        base_dst = REG_W'(bd); base_srca = REG_W'(ba); base_srcb = REG_W'(bb);
        vec_flags = fl; remap_en = rm;
        iss_ready = stall ? lfsr[0] : 1'b1;
        start = 1'b1;
        tick();
        start = 1'b0;
        pmask = ~mk;  // R2: later mask changes must not matter
        n = 0;
        while ((m_busy || m_done) && !wd) begin
            if (midstart && n == 2) begin  // R10: request while busy
                start = 1'b1;
                base_dst = base_dst + 7; base_srca = base_srca + 3;
                vec_flags = ~fl; remap_en = ~rm; vl = 1;
            end else start = 1'b0;
            iss_ready = stall ? (lfsr[0] | lfsr[3]) : 1'b1;
            tick();
            n++;
        end
        start = 1'b0;
        tick();
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; vl = '0; pmask = '0;
        base_dst = '0; base_srca = '0; base_srcb = '0;
        vec_flags = '0; remap_en = 1'b0; iss_ready = 1'b1;
        m_len = 1;
        @(negedge clk);
        ctx = "reset";
        tick(); tick();
        // R11: reset state
        check(iss_valid == 1'b0, "R11", iss_valid, 0);
        check(done == 1'b0, "R11", done, 0);
        check(iss_we == 1'b0, "R11", iss_we, 0);
        rst = 1'b0;
        tick();

        run_seq("R1 all-vector",   8, 64'hA5,                 10, 20, 30, 3'b111, 0, 0, 0);
        run_seq("R4 mixed stall",  6, 64'h2D,                 40, 50, 60, 3'b010, 0, 1, 0);
        run_seq("R8 empty",        0, 64'hFF,                  1,  2,  3, 3'b111, 0, 0, 0);
        run_seq("R1 single",       1, 64'h0,                   5,  6,  7, 3'b001, 0, 0, 0);
        run_seq("R3 wrap full",   64, 64'hF0F0_1234_8000_0001, 100, 90, 3, 3'b101, 0, 1, 0);
        run_seq("R9 clamp",      100, 64'hFFFF_0000_FFFF_0000,  0, 64, 127, 3'b110, 0, 0, 0);
        run_seq("R5 remap",        8, 64'h5A,                  16, 32, 48, 3'b111, 1, 1, 0);
        run_seq("R10 busy start",  8, 64'hC3,                  20, 21, 22, 3'b011, 0, 0, 1);
        run_seq("R6 stall scalar", 5, 64'h1F,                  70, 71, 72, 3'b000, 0, 1, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule